// File: doc/BRIEF.md
# Asynchronous Interrupt Pending Arbiter

This block sits beside a processor core's exception entry logic and decides which asynchronous event, if any, should be taken next. It watches three sources: an imprecise floating-point enabled exception (derived from the two floating-point exception mode bits of the machine state and the enabled-exception summary bit of the floating-point status), a level-sensitive external interrupt line, and a single-cycle pulse from the decrementer when it expires.

When a source is deliverable and no request is outstanding, the arbiter raises a registered take request. The request carries the vector offset and the extra bits the entry logic must OR into the saved machine state register. The request is held unchanged until the core returns a one-cycle taken acknowledge. Each source clears in its own way. The external source mirrors its line and ignores acknowledges. The decrementer source is latched and cleared only when its own request is taken. The floating-point condition lives entirely in its inputs.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `take_req_o` is low and both pending flags are clear; no request appears before a source is seen.
- R2: The external pending flag is the line level registered once; it sets one cycle after the line rises, clears one cycle after it falls, and an acknowledge of an external request does not clear it, so a line still held high is requested again.
- R3: A `dec_expire_i` pulse latches the decrementer pending flag, which stays set until a decrementer request is acknowledged and is not cleared by acknowledging any other source.
- R4: If a decrementer expiry pulse arrives in the same cycle as the acknowledge of a decrementer request, the pending flag stays set and the decrementer is requested again.
- R5: The floating-point source is deliverable whenever `fp_sum_i` is high and either bit of `fp_mode_i` is high, regardless of `ext_en_i`; it wins over all others and uses vector 0x700 with extra-bit value having bit 20 (enabled exception) and bit 15 (subsequent instruction) set, all other bits zero.
- R6: The external source beats the decrementer; the external uses vector 0x500 and the decrementer 0x900, both with all extra bits zero.
- R7: External and decrementer sources are deliverable only while `ext_en_i` is high; when the enable rises with a source already pending, the request appears on the next cycle.
- R8: An idle arbiter that sees a deliverable source at a clock edge shows the request after that edge; the request, vector and extra bits then stay constant, even if inputs change, until the acknowledge; after an acknowledged edge the request is low for one cycle before the next evaluation can raise it.
- R9: A `take_ack_i` pulse while no request is outstanding has no effect on any pending flag or on later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_i | input | 1 | Level-sensitive external interrupt line |
| dec_expire_i | input | 1 | One-cycle decrementer expiry pulse |
| ext_en_i | input | 1 | Machine-state enable for external and decrementer sources |
| fp_mode_i | input | 2 | Floating-point exception mode bits |
| fp_sum_i | input | 1 | Floating-point enabled-exception summary bit |
| take_ack_i | input | 1 | One-cycle acknowledge that the request was taken |
| take_req_o | output | 1 | Take request, held until acknowledged |
| take_vec_o | output | VEC_W | Vector offset of the requested interrupt |
| take_srr_o | output | SRR_W | Extra bits to OR into the saved machine state |

## Verification
The assertions assume the acknowledge is only meaningful while a request is outstanding and that the external line is never raised again while its pending flag is set and enabled; a stray acknowledge is tolerated by design and is driven on purpose. The stimulus moves the external line only in clean level changes separated by at least one cycle and issues acknowledges at chosen points, and the bench counts any rise of the line while its model flag is set and enabled as a failure. Expiry pulses are kept to single cycles, including one placed exactly on a decrementer acknowledge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FP   = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_DEC  = 2'd3
  } irq_src_e;

endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track (
  input  logic clk,
  input  logic rst,
  input  logic ext_irq_i,
  input  logic dec_expire_i,
  input  logic dec_clr_i,
  output logic ext_pend_o,
  output logic dec_pend_o
);

  logic ext_q;
  logic dec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q <= 1'b0;
      dec_q <= 1'b0;
    end else begin
      ext_q <= ext_irq_i;
      if (dec_expire_i)
        dec_q <= 1'b1;
      else if (dec_clr_i)
        dec_q <= 1'b0;
    end
  end

  assign ext_pend_o = ext_q;
  assign dec_pend_o = dec_q;

  AST_EXT_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ext_pend_o == $past(ext_irq_i)); // R2

  AST_DEC_LATCHES: assert property (@(posedge clk) disable iff (rst)
    dec_expire_i |=> dec_pend_o); // R4

  AST_DEC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    dec_clr_i && !dec_expire_i |=> !dec_pend_o); // R3

  AST_DEC_STICKY: assert property (@(posedge clk) disable iff (rst)
    dec_pend_o && !dec_clr_i |=> dec_pend_o); // R3

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_arb_pkg::*;
#(
  parameter int VEC_W    = 20,
  parameter int SRR_W    = 32,
  parameter int FP_VEC   = 'h700,
  parameter int EXT_VEC  = 'h500,
  parameter int DEC_VEC  = 'h900,
  parameter int FPEN_BIT = 20,
  parameter int SUBQ_BIT = 15
) (
  input  logic             ext_en_i,
  input  logic [1:0]       fp_mode_i,
  input  logic             fp_sum_i,
  input  logic             ext_pend_i,
  input  logic             dec_pend_i,
  output logic             hit_o,
  output irq_src_e         src_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [SRR_W-1:0] srr_o
);

  localparam logic [SRR_W-1:0] FP_SRR =
    (SRR_W'(1) << FPEN_BIT) | (SRR_W'(1) << SUBQ_BIT);

  logic fp_live, ext_live, dec_live;

  assign fp_live  = (|fp_mode_i) && fp_sum_i;
  assign ext_live = ext_en_i && ext_pend_i;
  assign dec_live = ext_en_i && dec_pend_i;

  always_comb begin
    hit_o = 1'b1;
    src_o = SRC_NONE;
    vec_o = '0;
    srr_o = '0;
    if (fp_live) begin
      src_o = SRC_FP;
      vec_o = VEC_W'(FP_VEC);
      srr_o = FP_SRR;
    end else if (ext_live) begin
      src_o = SRC_EXT;
      vec_o = VEC_W'(EXT_VEC);
    end else if (dec_live) begin
      src_o = SRC_DEC;
      vec_o = VEC_W'(DEC_VEC);
    end else begin
      hit_o = 1'b0;
    end
  end

endmodule

// File: rtl/irq_req_hold.sv
module irq_req_hold
  import irq_arb_pkg::*;
#(
  parameter int VEC_W = 20,
  parameter int SRR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  irq_src_e         src_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [SRR_W-1:0] srr_i,
  input  logic             ack_i,
  output logic             req_o,
  output irq_src_e         src_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [SRR_W-1:0] srr_o
);

  logic             req_q;
  irq_src_e         src_q;
  logic [VEC_W-1:0] vec_q;
  logic [SRR_W-1:0] srr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      src_q <= SRC_NONE;
      vec_q <= '0;
      srr_q <= '0;
    end else if (req_q) begin
      if (ack_i) begin
        req_q <= 1'b0;
        src_q <= SRC_NONE;
      end
    end else if (hit_i) begin
      req_q <= 1'b1;
      src_q <= src_i;
      vec_q <= vec_i;
      srr_q <= srr_i;
    end
  end

  assign req_o = req_q;
  assign src_o = src_q;
  assign vec_o = vec_q;
  assign srr_o = srr_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    req_o && !ack_i |=> req_o && $stable(vec_o) && $stable(srr_o)); // R8

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    req_o && ack_i |=> !req_o); // R8

  AST_IDLE_RAISE: assert property (@(posedge clk) disable iff (rst)
    !req_o && hit_i |=> req_o && vec_o == $past(vec_i)); // R8

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int VEC_W    = 20,
  parameter int SRR_W    = 32,
  parameter int FP_VEC   = 'h700,
  parameter int EXT_VEC  = 'h500,
  parameter int DEC_VEC  = 'h900,
  parameter int FPEN_BIT = 20,
  parameter int SUBQ_BIT = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_irq_i,
  input  logic             dec_expire_i,
  input  logic             ext_en_i,
  input  logic [1:0]       fp_mode_i,
  input  logic             fp_sum_i,
  input  logic             take_ack_i,
  output logic             take_req_o,
  output logic [VEC_W-1:0] take_vec_o,
  output logic [SRR_W-1:0] take_srr_o
);

  logic             ext_pend, dec_pend, dec_clr;
  logic             hit;
  irq_src_e         sel_src, held_src;
  logic [VEC_W-1:0] sel_vec;
  logic [SRR_W-1:0] sel_srr;

  assign dec_clr = take_req_o && take_ack_i && (held_src == SRC_DEC);

  irq_pend_track u_pend (
    .clk          (clk),
    .rst          (rst),
    .ext_irq_i    (ext_irq_i),
    .dec_expire_i (dec_expire_i),
    .dec_clr_i    (dec_clr),
    .ext_pend_o   (ext_pend),
    .dec_pend_o   (dec_pend)
  );

  irq_prio_sel #(
    .VEC_W(VEC_W), .SRR_W(SRR_W), .FP_VEC(FP_VEC), .EXT_VEC(EXT_VEC),
    .DEC_VEC(DEC_VEC), .FPEN_BIT(FPEN_BIT), .SUBQ_BIT(SUBQ_BIT)
  ) u_sel (
    .ext_en_i   (ext_en_i),
    .fp_mode_i  (fp_mode_i),
    .fp_sum_i   (fp_sum_i),
    .ext_pend_i (ext_pend),
    .dec_pend_i (dec_pend),
    .hit_o      (hit),
    .src_o      (sel_src),
    .vec_o      (sel_vec),
    .srr_o      (sel_srr)
  );

  irq_req_hold #(.VEC_W(VEC_W), .SRR_W(SRR_W)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .hit_i (hit),
    .src_i (sel_src),
    .vec_i (sel_vec),
    .srr_i (sel_srr),
    .ack_i (take_ack_i),
    .req_o (take_req_o),
    .src_o (held_src),
    .vec_o (take_vec_o),
    .srr_o (take_srr_o)
  );

  AST_FP_FIRST: assert property (@(posedge clk) disable iff (rst)
    !take_req_o && (|fp_mode_i) && fp_sum_i |=> take_req_o && take_vec_o == VEC_W'(FP_VEC)); // R5

  AST_GATED_BY_EN: assert property (@(posedge clk) disable iff (rst)
    !take_req_o && !ext_en_i && !((|fp_mode_i) && fp_sum_i) |=> !take_req_o); // R7

  AST_EXT_OVER_DEC: assert property (@(posedge clk) disable iff (rst)
    !take_req_o && ext_en_i && ext_pend && !((|fp_mode_i) && fp_sum_i)
      |=> take_vec_o == VEC_W'(EXT_VEC)); // R6

  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    take_req_o |-> take_vec_o == VEC_W'(FP_VEC) || take_vec_o == VEC_W'(EXT_VEC)
                   || take_vec_o == VEC_W'(DEC_VEC)); // R6

endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;

  localparam int VEC_W = 20;
  localparam int SRR_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_irq = 1'b0, dec_exp = 1'b0, ext_en = 1'b0, fp_sum = 1'b0, ack = 1'b0;
  logic [1:0] fp_mode = 2'b00;
  logic take_req;
  logic [VEC_W-1:0] take_vec;
  logic [SRR_W-1:0] take_srr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  // behavioural reference state
  int m_req = 0, m_vec = 0, m_srr = 0, m_src = 0; // src: 0 none, 1 fp, 2 ext, 3 dec
  int m_ext = 0, m_dec = 0;

  always #2.5 clk = ~clk;

  irq_arbiter u_dut (
    .clk(clk), .rst(rst), .ext_irq_i(ext_irq), .dec_expire_i(dec_exp),
    .ext_en_i(ext_en), .fp_mode_i(fp_mode), .fp_sum_i(fp_sum),
    .take_ack_i(ack), .take_req_o(take_req), .take_vec_o(take_vec),
    .take_srr_o(take_srr)
  );

  task automatic model_edge();
    int n_req, n_vec, n_srr, n_src, n_dec;
    bit fp;
    if (rst) begin
      m_req = 0; m_vec = 0; m_srr = 0; m_src = 0; m_ext = 0; m_dec = 0;
      return;
    end
    n_req = m_req; n_vec = m_vec; n_srr = m_srr; n_src = m_src;
    fp = (fp_mode != 2'b00) && fp_sum;
    if (m_req != 0) begin
      if (ack) begin n_req = 0; n_src = 0; end
    end else if (fp) begin
      n_req = 1; n_vec = 'h700; n_srr = (1 << 20) | (1 << 15); n_src = 1;
    end else if (ext_en && m_ext != 0) begin
      n_req = 1; n_vec = 'h500; n_srr = 0; n_src = 2;
    end else if (ext_en && m_dec != 0) begin
      n_req = 1; n_vec = 'h900; n_srr = 0; n_src = 3;
    end
    n_dec = m_dec;
    if (dec_exp) n_dec = 1;
    else if (m_req != 0 && ack && m_src == 3) n_dec = 0;
    m_ext = ext_irq ? 1 : 0;
    m_dec = n_dec;
    m_req = n_req; m_vec = n_vec; m_srr = n_srr; m_src = n_src;
  endtask

  task automatic compare();
    checks++;
    if (take_req !== (m_req != 0)) begin
      errors++;
      $display("FAIL %s req actual=%0b expected=%0d t=%0t", tag, take_req, m_req, $time);
    end else if (m_req != 0 && (take_vec !== VEC_W'(m_vec) || take_srr !== SRR_W'(m_srr))) begin
      errors++;
      $display("FAIL %s vec/srr actual=%h/%h expected=%h/%h t=%0t",
               tag, take_vec, take_srr, m_vec, m_srr, $time);
    end
  endtask

  // drive inputs for one cycle, advance one edge, compare after it
  task automatic step(input bit e, input bit d, input bit en, input bit [1:0] fm,
                      input bit fs, input bit a);
    checks++;
    if (e && !ext_irq && m_ext != 0 && ext_en) begin
      errors++;
      $display("FAIL R2 line raised while pending actual=1 expected=0");
    end
    ext_irq = e; dec_exp = d; ext_en = en; fp_mode = fm; fp_sum = fs; ack = a;
    @(posedge clk);
    model_edge();
    #1;
    compare();
  endtask

  task automatic idle(input int n, input bit e, input bit en);
    for (int i = 0; i < n; i++) step(e, 1'b0, en, 2'b00, 1'b0, 1'b0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    // R1 reset state
    tag = "R1";
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0);
    rst = 1'b0;
    idle(3, 1'b0, 1'b0);

    // R7 external pending but disabled, then enabled
    tag = "R7";
    idle(4, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    // R8 hold while enable drops, then acknowledge
    tag = "R8";
    idle(3, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1);
    idle(2, 1'b1, 1'b0);
    // R2 line still high: requested again after acknowledge
    tag = "R2";
    idle(2, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1);
    idle(2, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1);
    idle(4, 1'b0, 1'b1);

    // R3 decrementer once only
    tag = "R3";
    step(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0);
    idle(3, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1);
    idle(4, 1'b0, 1'b1);

    // R6 external beats decrementer; decrementer survives the external ack
    tag = "R6";
    step(1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
    idle(2, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    idle(1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1);
    idle(3, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1);
    idle(2, 1'b0, 1'b1);

    // R4 expiry on the same edge as the decrementer acknowledge
    tag = "R4";
    step(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0);
    idle(2, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1);
    idle(3, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1);
    idle(3, 1'b0, 1'b1);

    // R5 floating-point source wins, independent of enable
    tag = "R5";
    step(1'b1, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1);
    idle(1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1);
    idle(3, 1'b0, 1'b1);

    // R9 stray acknowledges while idle leave the decrementer pending
    tag = "R9";
    step(1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    idle(2, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1);
    idle(3, 1'b0, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule